// File: doc/BRIEF.md
# Terminator Bus Mode Filter and Control

This block picks the operating mode of a multimode bus terminator and drives the logic enables that set up the termination network around it. Two comparators watch the shared mode sense line and report, as logic levels, whether that line sits above a low threshold and whether it sits above a high threshold. The block turns this pair into a mode: single-ended, low-voltage differential (LVD), or high-power differential. A mode that differs from the current one is adopted only after it has been seen for a long, noise-tolerant window. The window is counted in ticks of a slow timebase strobe.

From the current mode, a disconnect input and a master/slave input, the block drives four things. It sets the one-hot status outputs. It closes the switch group that suits the mode. It selects the regulator setpoint and turns the regulator on. It enables the sense-line driver. The comparator, disconnect and master/slave inputs arrive from pins, so each one passes through a clock-domain synchronizer before it is used. The timebase strobe is on-chip and synchronous to the block's clock.

Top module: `term_mode_ctrl`

## Requirements
- R1: The synchronized comparator pair is decoded into a mode. Low flag 0 with high flag 0 means single-ended. Low flag 1 with high flag 0 means LVD. High flag 1 means high-power differential, whatever the low flag is, so the impossible pair (high 1, low 0) also decodes to high-power differential.
- R2: While reset is held, and after it is released, the current mode is high-power differential.
- R3: The current mode changes only on a clock edge where `tick` is high. A mode seen cleanly on `DELAY_TICKS` consecutive ticks becomes current on the last of those ticks and not earlier. The delay is the same for every pair of modes.
- R4: A tick that samples the current mode lowers the pending count by one, saturating at zero. A tick that samples a third mode, different from both the current and the pending one, also lowers it by one. In neither case is the pending change cleared outright.
- R5: When a change completes, the count returns to zero. A further change can then begin on the very next tick and takes another full `DELAY_TICKS` ticks.
- R6: Exactly one of `stat_se`, `stat_lvd` and `stat_hpd` is high, and it names the current mode.
- R7: While `disconnect` is high, both switch groups are open and the regulator, its setpoint select and the sense driver are all off. Mode detection, the filter and the status outputs keep working.
- R8: In high-power differential mode while connected, both switch groups are open, the regulator is on, and the low (LVD) setpoint is selected (`reg_hi_sel` = 0).
- R9: In single-ended mode while connected, `sw_se_gnd` and `reg_hi_sel` are high. In LVD mode while connected, `sw_lvd_y` is high and `reg_hi_sel` is low. The two switch groups are never closed together.
- R10: `sense_drv_en` is high exactly when the block is connected and `master` is high, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle timebase strobe (e.g. 1 kHz) |
| sense_above_lo | input | 1 | Comparator: sense line above low threshold (asynchronous) |
| sense_above_hi | input | 1 | Comparator: sense line above high threshold (asynchronous) |
| disconnect | input | 1 | High (or pulled-up open) detaches the terminator (asynchronous) |
| master | input | 1 | High lets this unit drive the sense line (asynchronous) |
| stat_se | output | 1 | Status: single-ended mode |
| stat_lvd | output | 1 | Status: LVD mode |
| stat_hpd | output | 1 | Status: high-power differential mode |
| sw_se_gnd | output | 1 | Close positive-line-to-ground switches |
| sw_lvd_y | output | 1 | Close Y-network switches |
| reg_on | output | 1 | Termination regulator enable |
| reg_hi_sel | output | 1 | Select the high (single-ended) regulator setpoint |
| sense_drv_en | output | 1 | Sense-line driver enable |

## Verification
The hardest situation to bring about is a pending change whose count is pulled down by noise of both kinds. One kind samples the current mode; the other samples a third mode that is neither current nor pending. Either kind must only delay adoption, not reset it. The bench reaches this by sending an exact number of ticks of one mode, then a burst of ticks of the other mode, then ticks of the first mode again. It checks that the change lands on precisely the tick where the net agreeing count reaches the delay, with one check a tick before and one on that tick.

// File: rtl/term_mode_pkg.sv
package term_mode_pkg;

    typedef enum logic [1:0] {
        MODE_SE  = 2'd0,
        MODE_LVD = 2'd1,
        MODE_HPD = 2'd2
    } mode_t;

    typedef struct packed {
        logic stat_se;
        logic stat_lvd;
        logic stat_hpd;
        logic sw_se_gnd;
        logic sw_lvd_y;
        logic reg_on;
        logic reg_hi_sel;
        logic sense_drv_en;
    } term_ctrl_t;

    // Index of each raw input inside the synchronizer vector
    localparam int IN_LO     = 0;
    localparam int IN_HI     = 1;
    localparam int IN_MASTER = 2;
    localparam int IN_DISC   = 3;
    localparam int IN_W      = 4;

    // High flag dominates: covers the impossible (hi=1, lo=0) pair too
    function automatic mode_t classify(input logic above_lo, input logic above_hi);
        if (above_hi)      return MODE_HPD;
        else if (above_lo) return MODE_LVD;
        else               return MODE_SE;
    endfunction

endpackage

// File: rtl/term_in_sync.sv
module term_in_sync #(
    parameter int         WIDTH   = 4,
    parameter int         STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)        stage_q[s] <= RST_VAL;
                else if (s == 0) stage_q[s] <= din;
                else            stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/term_mode_filter.sv
module term_mode_filter
    import term_mode_pkg::*;
#(
    parameter int DELAY_TICKS = 180
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  mode_t seen_mode,
    output mode_t cur_mode
);
    localparam int CNT_W = $clog2(DELAY_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_TICKS - 1);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    mode_t            cur_q, cand_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= MODE_HPD;
            cand_q <= MODE_HPD;
            cnt_q  <= '0;
        end else if (tick) begin
            if (seen_mode == cur_q) begin
                if (cnt_q != '0) cnt_q <= cnt_q - ONE;
            end else if (cnt_q == '0) begin
                cand_q <= seen_mode;
                if (DELAY_TICKS <= 1) cur_q <= seen_mode;
                else                  cnt_q <= ONE;
            end else if (seen_mode == cand_q) begin
                if (cnt_q == LAST) begin
                    cur_q <= cand_q;
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + ONE;
                end
            end else begin
                cnt_q <= cnt_q - ONE;
            end
        end
    end

    assign cur_mode = cur_q;
endmodule

// File: rtl/term_ctrl_decode.sv
module term_ctrl_decode
    import term_mode_pkg::*;
(
    input  mode_t      mode,
    input  logic       connected,
    input  logic       is_master,
    output term_ctrl_t ctrl
);
    always_comb begin
        ctrl              = '0;
        ctrl.stat_se      = (mode == MODE_SE);
        ctrl.stat_lvd     = (mode == MODE_LVD);
        ctrl.stat_hpd     = (mode == MODE_HPD);
        ctrl.reg_on       = connected;
        ctrl.sense_drv_en = connected & is_master;
        if (connected) begin
            unique case (mode)
                MODE_SE: begin
                    ctrl.sw_se_gnd  = 1'b1;
                    ctrl.reg_hi_sel = 1'b1;
                end
                MODE_LVD: ctrl.sw_lvd_y = 1'b1;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/term_mode_ctrl.sv
module term_mode_ctrl
    import term_mode_pkg::*;
#(
    parameter int DELAY_TICKS = 180,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic sense_above_lo,
    input  logic sense_above_hi,
    input  logic disconnect,
    input  logic master,
    output logic stat_se,
    output logic stat_lvd,
    output logic stat_hpd,
    output logic sw_se_gnd,
    output logic sw_lvd_y,
    output logic reg_on,
    output logic reg_hi_sel,
    output logic sense_drv_en
);
    localparam logic [IN_W-1:0] SYNC_RST = IN_W'((1 << IN_DISC) | (1 << IN_HI) | (1 << IN_LO));

    logic [IN_W-1:0] raw_in, sync_in;
    logic            conn_s, master_s;
    mode_t           seen_mode, cur_mode;
    term_ctrl_t      ctrl;

    always_comb begin
        raw_in            = '0;
        raw_in[IN_LO]     = sense_above_lo;
        raw_in[IN_HI]     = sense_above_hi;
        raw_in[IN_MASTER] = master;
        raw_in[IN_DISC]   = disconnect;
    end

    term_in_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk(clk), .rst(rst), .din(raw_in), .dout(sync_in)
    );

    assign conn_s    = ~sync_in[IN_DISC];
    assign master_s  = sync_in[IN_MASTER];
    assign seen_mode = classify(sync_in[IN_LO], sync_in[IN_HI]);

    term_mode_filter #(.DELAY_TICKS(DELAY_TICKS)) u_filter (
        .clk(clk), .rst(rst), .tick(tick), .seen_mode(seen_mode), .cur_mode(cur_mode)
    );

    term_ctrl_decode u_decode (
        .mode(cur_mode), .connected(conn_s), .is_master(master_s), .ctrl(ctrl)
    );

    assign stat_se      = ctrl.stat_se;
    assign stat_lvd     = ctrl.stat_lvd;
    assign stat_hpd     = ctrl.stat_hpd;
    assign sw_se_gnd    = ctrl.sw_se_gnd;
    assign sw_lvd_y     = ctrl.sw_lvd_y;
    assign reg_on       = ctrl.reg_on;
    assign reg_hi_sel   = ctrl.reg_hi_sel;
    assign sense_drv_en = ctrl.sense_drv_en;
endmodule

// File: rtl/term_mode_ctrl_chk.sv
module term_mode_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic tick,
    input logic conn_s,
    input logic master_s,
    input logic stat_se,
    input logic stat_lvd,
    input logic stat_hpd,
    input logic sw_se_gnd,
    input logic sw_lvd_y,
    input logic reg_on,
    input logic reg_hi_sel,
    input logic sense_drv_en
);
    assert_status_onehot_R6: assert property (@(posedge clk) disable iff (rst)
        $countones({stat_se, stat_lvd, stat_hpd}) == 1);

    assert_change_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable({stat_se, stat_lvd, stat_hpd}) |-> $past(tick));

    assert_disc_all_off_R7: assert property (@(posedge clk) disable iff (rst)
        !conn_s |-> !(sw_se_gnd || sw_lvd_y || reg_on || reg_hi_sel || sense_drv_en));

    assert_switch_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(sw_se_gnd && sw_lvd_y));

    assert_hpd_open_low_set_R8: assert property (@(posedge clk) disable iff (rst)
        stat_hpd |-> !(sw_se_gnd || sw_lvd_y || reg_hi_sel));

    assert_driver_gate_R10: assert property (@(posedge clk) disable iff (rst)
        sense_drv_en == (conn_s && master_s));
endmodule

bind term_mode_ctrl term_mode_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .tick(tick), .conn_s(conn_s), .master_s(master_s),
    .stat_se(stat_se), .stat_lvd(stat_lvd), .stat_hpd(stat_hpd),
    .sw_se_gnd(sw_se_gnd), .sw_lvd_y(sw_lvd_y), .reg_on(reg_on),
    .reg_hi_sel(reg_hi_sel), .sense_drv_en(sense_drv_en)
);

// File: tb/test_term_mode_ctrl.sv
module test_term_mode_ctrl;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic lo = 1'b1, hi = 1'b1, disc = 1'b0, mstr = 1'b1;
    logic stat_se, stat_lvd, stat_hpd, sw_se_gnd, sw_lvd_y, reg_on, reg_hi_sel, sense_drv_en;

    always #5 clk = ~clk;

    term_mode_ctrl i_term_mode_ctrl (
        .clk(clk), .rst(rst), .tick(tick),
        .sense_above_lo(lo), .sense_above_hi(hi), .disconnect(disc), .master(mstr),
        .stat_se(stat_se), .stat_lvd(stat_lvd), .stat_hpd(stat_hpd),
        .sw_se_gnd(sw_se_gnd), .sw_lvd_y(sw_lvd_y), .reg_on(reg_on),
        .reg_hi_sel(reg_hi_sel), .sense_drv_en(sense_drv_en)
    );

    typedef struct {
        string      tag;
        logic [7:0] exp;
    } item_t;

    item_t q[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // vector: {se, lvd, hpd, sw_se_gnd, sw_lvd_y, reg_on, reg_hi_sel, drv}
    localparam logic [7:0] E_HPD_M  = 8'b001_00101;
    localparam logic [7:0] E_HPD_S  = 8'b001_00100;
    localparam logic [7:0] E_SE_M   = 8'b100_10111;
    localparam logic [7:0] E_LVD_M  = 8'b010_01101;
    localparam logic [7:0] E_HPD_D  = 8'b001_00000;
    localparam logic [7:0] E_LVD_D  = 8'b010_00000;

    // monitor: pops expectations and compares against the ports
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it  = q.pop_front();
                act = {stat_se, stat_lvd, stat_hpd, sw_se_gnd, sw_lvd_y, reg_on, reg_hi_sel, sense_drv_en};
                n_checks++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %b expected %b", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic expect_out(input string tag, input logic [7:0] exp);
        item_t it;
        it.tag = tag;
        it.exp = exp;
        q.push_back(it);
        wait (q.size() == 0);
    endtask

    task automatic set_in(input logic l, input logic h, input logic d, input logic m);
        @(negedge clk);
        lo = l; hi = h; disc = d; mstr = m;
        repeat (4) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        expect_out("R2 R8 R10 reset state HPD", E_HPD_M);

        // clean change to single-ended
        set_in(0, 0, 0, 1);
        ticks(179);
        expect_out("R3 SE not before delay", E_HPD_M);
        ticks(1);
        expect_out("R3 R9 R1 SE adopted", E_SE_M);

        // noise from current mode only delays the change
        set_in(1, 0, 0, 1);
        ticks(100);
        set_in(0, 0, 0, 1);
        ticks(10);
        set_in(1, 0, 0, 1);
        ticks(89);
        expect_out("R4 LVD held back by noise", E_SE_M);
        ticks(1);
        expect_out("R4 R9 LVD adopted", E_LVD_M);

        // immediate follow-up change takes a full window
        set_in(0, 0, 0, 1);
        ticks(179);
        expect_out("R5 SE not before full window", E_LVD_M);
        ticks(1);
        expect_out("R5 SE adopted", E_SE_M);

        // impossible pair decodes as HPD
        set_in(0, 1, 0, 1);
        ticks(179);
        expect_out("R1 invalid pair pending", E_SE_M);
        ticks(1);
        expect_out("R1 R8 invalid pair gives HPD", E_HPD_M);

        // slave: driver off
        set_in(0, 1, 0, 0);
        expect_out("R10 slave driver off", E_HPD_S);

        // disconnected: controls off, detection continues
        set_in(0, 1, 1, 1);
        expect_out("R7 disconnect all off", E_HPD_D);
        set_in(1, 0, 1, 1);
        ticks(179);
        expect_out("R7 disconnected pending", E_HPD_D);
        ticks(1);
        expect_out("R7 R6 status tracks while disconnected", E_LVD_D);
        set_in(1, 0, 0, 1);
        expect_out("R7 reconnect restores LVD", E_LVD_M);

        // third-mode noise counts down too
        set_in(1, 1, 0, 1);
        ticks(50);
        set_in(0, 0, 0, 1);
        ticks(20);
        set_in(1, 1, 0, 1);
        ticks(149);
        expect_out("R4 third-mode noise delays", E_LVD_M);
        ticks(1);
        expect_out("R4 R6 HPD adopted", E_HPD_M);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule